// File: doc/BRIEF.md
# Floating-Point Round and Pack Unit

This block takes a floating-point value in unpacked form and turns it into a packed word with sign, exponent field and mantissa field, along with exception flags. The input has a class code, a sign, a signed unbiased exponent and a wide fraction. For normal values the fraction carries an explicit leading one, then the mantissa bits, then a set of guard bits that rounding removes. One of six rounding modes is chosen on every cycle. Per-cycle controls also select three behaviours: flushing of results that would be denormal, whether tininess is judged before or after rounding, and an alternative encoding that has no infinity or NaN and uses the all-ones exponent as an ordinary value.

The unit sits after an arithmetic datapath that has already formed an exact or sticky-jammed result. Each cycle it registers one packed result and its flags, so the latency is one cycle. Widths are parameters, and the defaults give single precision with eight guard bits.

Top module: `fpr_round_pack`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN, and 5..7 are treated as zero. Rounding-mode codes are 0 nearest-even, 1 nearest ties-away, 2 toward zero, 3 toward plus infinity, 4 toward minus infinity, 5 to odd, and 6..7 act as toward zero. For a normal input whose biased exponent (unbiased plus 127) is positive, nearest-even adds half of a kept LSB unless the discarded guard bits are exactly one half and the kept LSB is 0.
- R2: Ties-away always adds half an LSB. Toward zero adds nothing.
- R3: Toward plus infinity adds the full guard mask when the sign is 0 and nothing when it is 1. Toward minus infinity does the reverse.
- R4: Round to odd adds the full guard mask only when the kept LSB is 0.
- R5: Nonzero guard bits raise inexact (flag nx), and only in that case is the increment added. A carry out of the fraction top renormalises the value: the exponent goes up by one and the mantissa becomes zero.
- R6: With the alternative encoding off, a rounded biased exponent of 255 or more raises overflow and inexact. The result saturates to exponent 254 with an all-ones mantissa under toward zero, round to odd, toward plus infinity with sign 1, and toward minus infinity with sign 0. In every other case it is infinity (exponent 255, mantissa 0).
- R7: With the alternative encoding on, exponent 255 is packed as a normal value with no flag. A rounded biased exponent above 255 gives an all-ones exponent and mantissa and raises only invalid (nv).
- R8: A normal input with biased exponent 0 or below and flush enabled gives a zero with the input sign, and raises only output-denormal (od).
- R9: Without flush, a sub-minimum value counts as tiny when before-rounding detection is selected or the biased exponent is negative. Otherwise it counts as tiny only when rounding the unshifted fraction with the mode increment would not carry out.
- R10: A sub-minimum value is shifted right by one minus the biased exponent, with every shifted-out bit ORed into the lowest bit. The increment is then chosen again from the shifted fraction and applied when guard bits remain. The packed exponent is 1 if the shifted and rounded leading bit is set and 0 otherwise.
- R11: Underflow (uf) is raised exactly when the value is tiny and the denormal result is inexact.
- R12: Zero-class inputs pack as signed zero and infinity-class inputs as exponent 255 with mantissa 0. Both NaN classes pack with exponent 255 and the mantissa taken from fraction bits 30..8. None of these raises a flag.
- R13: Result and flags are registered one cycle after the inputs. A synchronous reset clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 3 | Class code of the value |
| sign_i | input | 1 | Sign |
| exp_i | input | EXP_W+3 | Signed unbiased exponent |
| frac_i | input | 1+MAN_W+GRD_W | Fraction: leading bit, mantissa, guard bits |
| rmode_i | input | 3 | Rounding-mode code |
| ftz_i | input | 1 | Flush denormal results to zero |
| tiny_before_i | input | 1 | Judge tininess before rounding |
| alt_i | input | 1 | Alternative encoding without infinity or NaN |
| result_o | output | 1+EXP_W+MAN_W | Packed word |
| nx_o | output | 1 | Inexact |
| of_o | output | 1 | Overflow |
| uf_o | output | 1 | Underflow |
| nv_o | output | 1 | Invalid (alternative-encoding overflow) |
| od_o | output | 1 | Output denormal flushed |

## Verification
The hardest case to reach is the edge between tininess detection before and after rounding. The biased exponent must be exactly zero and the fraction must be so close to all ones that rounding at full precision carries out. The denormal path then also rounds up into the smallest normal exponent. The stimulus applies that exact fraction with both tininess settings and checks that underflow follows the setting. Further directed vectors reach shifts wider than the fraction, to test the sticky bit and the directed modes, and each overflow mode with both signs. A long run of random vectors covers the space between these points.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fpr_cls_e;

    typedef enum logic [2:0] {
        RM_NE = 3'd0,
        RM_NA = 3'd1,
        RM_TZ = 3'd2,
        RM_UP = 3'd3,
        RM_DN = 3'd4,
        RM_OD = 3'd5
    } fpr_rm_e;

    typedef struct packed {
        logic nx;
        logic of;
        logic uf;
        logic nv;
        logic od;
    } fpr_flags_t;

    localparam fpr_flags_t FLAGS_NONE = '{nx: 1'b0, of: 1'b0, uf: 1'b0, nv: 1'b0, od: 1'b0};

    // Overflow saturates to the largest finite value instead of infinity
    function automatic logic sat_on_ovf(input logic [2:0] rm, input logic sign);
        logic s;
        case (rm)
            RM_NE, RM_NA: s = 1'b0;
            RM_UP:        s = sign;
            RM_DN:        s = ~sign;
            default:      s = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpr_inc_sel.sv
module fpr_inc_sel
    import fpr_pkg::*;
#(
    parameter int FRAC_W = 32,
    parameter int GRD_W  = 8
) (
    input  logic [2:0]        rm,
    input  logic              sign,
    input  logic [FRAC_W-1:0] frac,
    output logic [FRAC_W-1:0] inc
);
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (GRD_W - 1);
    localparam logic [FRAC_W-1:0] MASK = (FRAC_W'(1) << GRD_W) - FRAC_W'(1);

    always_comb begin
        case (rm)
            RM_NE:   inc = (frac[GRD_W:0] != HALF[GRD_W:0]) ? HALF : '0;
            RM_NA:   inc = HALF;
            RM_UP:   inc = sign ? '0 : MASK;
            RM_DN:   inc = sign ? MASK : '0;
            RM_OD:   inc = frac[GRD_W] ? '0 : MASK;
            default: inc = '0;
        endcase
    end
endmodule

// File: rtl/fpr_norm_path.sv
module fpr_norm_path
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int GRD_W = 8,
    localparam int FRAC_W = 1 + MAN_W + GRD_W,
    localparam int EB_W   = EXP_W + 4
) (
    input  logic                   sign,
    input  logic [2:0]             rm,
    input  logic                   alt,
    input  logic signed [EB_W-1:0] ebias,
    input  logic [FRAC_W-1:0]      frac,
    input  logic [FRAC_W-1:0]      inc,
    output logic [EXP_W-1:0]       exp_o,
    output logic [MAN_W-1:0]       man_o,
    output fpr_flags_t             flags_o
);
    localparam int EMAX = (1 << EXP_W) - 1;

    logic [FRAC_W:0]        sum;
    logic                   grd_nz;
    logic [FRAC_W-1:0]      f1;
    logic signed [EB_W-1:0] e1;

    assign sum    = {1'b0, frac} + {1'b0, inc};
    assign grd_nz = |frac[GRD_W-1:0];

    always_comb begin
        f1 = frac;
        e1 = ebias;
        if (grd_nz) begin
            if (sum[FRAC_W]) begin
                f1 = sum[FRAC_W:1];
                e1 = ebias + EB_W'(1);
            end else begin
                f1 = sum[FRAC_W-1:0];
            end
        end
    end

    always_comb begin
        flags_o    = FLAGS_NONE;
        flags_o.nx = grd_nz;
        exp_o      = e1[EXP_W-1:0];
        man_o      = f1[FRAC_W-2:GRD_W];
        if (alt) begin
            if (e1 > EMAX) begin
                flags_o = FLAGS_NONE;
                flags_o.nv = 1'b1;
                exp_o = '1;
                man_o = '1;
            end
        end else if (e1 >= EMAX) begin
            flags_o.of = 1'b1;
            flags_o.nx = 1'b1;
            if (sat_on_ovf(rm, sign)) begin
                exp_o = EXP_W'(EMAX - 1);
                man_o = '1;
            end else begin
                exp_o = '1;
                man_o = '0;
            end
        end
    end
endmodule

// File: rtl/fpr_sub_path.sv
module fpr_sub_path
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int GRD_W = 8,
    localparam int FRAC_W = 1 + MAN_W + GRD_W,
    localparam int EB_W   = EXP_W + 4
) (
    input  logic                   sign,
    input  logic [2:0]             rm,
    input  logic                   tiny_before,
    input  logic signed [EB_W-1:0] ebias,
    input  logic [FRAC_W-1:0]      frac,
    input  logic [FRAC_W-1:0]      inc0,
    output logic [EXP_W-1:0]       exp_o,
    output logic [MAN_W-1:0]       man_o,
    output fpr_flags_t             flags_o
);
    logic [FRAC_W:0]     full_sum;
    logic                tiny;
    logic [EB_W-1:0]     sh;
    logic [FRAC_W-1:0]   lost_mask;
    logic [FRAC_W-1:0]   f2;
    logic [FRAC_W-1:0]   inc2;
    logic [FRAC_W-1:0]   f3;
    logic                inexact;

    assign full_sum = {1'b0, frac} + {1'b0, inc0};
    assign tiny     = tiny_before | (ebias < 0) | ~full_sum[FRAC_W];
    assign sh       = EB_W'(1) - ebias;

    // Right shift with every lost bit jammed into bit 0
    always_comb begin
        if (sh >= EB_W'(FRAC_W)) begin
            lost_mask = '1;
            f2 = {{(FRAC_W-1){1'b0}}, |frac};
        end else begin
            lost_mask = ~({FRAC_W{1'b1}} << sh);
            f2 = (frac >> sh) | {{(FRAC_W-1){1'b0}}, |(frac & lost_mask)};
        end
    end

    fpr_inc_sel #(.FRAC_W(FRAC_W), .GRD_W(GRD_W)) u_inc_den (
        .rm   (rm),
        .sign (sign),
        .frac (f2),
        .inc  (inc2)
    );

    assign inexact = |f2[GRD_W-1:0];
    assign f3      = inexact ? (f2 + inc2) : f2;

    always_comb begin
        flags_o    = FLAGS_NONE;
        flags_o.nx = inexact;
        flags_o.uf = inexact & tiny;
        exp_o      = {{(EXP_W-1){1'b0}}, f3[FRAC_W-1]};
        man_o      = f3[FRAC_W-2:GRD_W];
    end
endmodule

// File: rtl/fpr_round_pack.sv
module fpr_round_pack
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int GRD_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [2:0]                       cls_i,
    input  logic                             sign_i,
    input  logic signed [EXP_W+2:0]          exp_i,
    input  logic [MAN_W+GRD_W:0]             frac_i,
    input  logic [2:0]                       rmode_i,
    input  logic                             ftz_i,
    input  logic                             tiny_before_i,
    input  logic                             alt_i,
    output logic [EXP_W+MAN_W:0]             result_o,
    output logic                             nx_o,
    output logic                             of_o,
    output logic                             uf_o,
    output logic                             nv_o,
    output logic                             od_o
);
    localparam int FRAC_W = 1 + MAN_W + GRD_W;
    localparam int EI_W   = EXP_W + 3;
    localparam int EB_W   = EXP_W + 4;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int RES_W  = 1 + EXP_W + MAN_W;

    logic signed [EB_W-1:0] ebias;
    logic [FRAC_W-1:0]      inc0;
    logic [EXP_W-1:0]       n_exp, d_exp;
    logic [MAN_W-1:0]       n_man, d_man;
    fpr_flags_t             n_flags, d_flags;
    logic [RES_W-1:0]       res_d;
    fpr_flags_t             flags_d;
    fpr_flags_t             flags_q;
    logic [RES_W-1:0]       res_q;

    assign ebias = $signed({exp_i[EI_W-1], exp_i}) + $signed(EB_W'(BIAS));

    fpr_inc_sel #(.FRAC_W(FRAC_W), .GRD_W(GRD_W)) u_inc_full (
        .rm   (rmode_i),
        .sign (sign_i),
        .frac (frac_i),
        .inc  (inc0)
    );

    fpr_norm_path #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_norm (
        .sign    (sign_i),
        .rm      (rmode_i),
        .alt     (alt_i),
        .ebias   (ebias),
        .frac    (frac_i),
        .inc     (inc0),
        .exp_o   (n_exp),
        .man_o   (n_man),
        .flags_o (n_flags)
    );

    fpr_sub_path #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_sub (
        .sign        (sign_i),
        .rm          (rmode_i),
        .tiny_before (tiny_before_i),
        .ebias       (ebias),
        .frac        (frac_i),
        .inc0        (inc0),
        .exp_o       (d_exp),
        .man_o       (d_man),
        .flags_o     (d_flags)
    );

    always_comb begin
        res_d   = {sign_i, {(RES_W-1){1'b0}}};
        flags_d = FLAGS_NONE;
        case (cls_i)
            CLS_INF:  res_d = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            CLS_QNAN,
            CLS_SNAN: res_d = {sign_i, {EXP_W{1'b1}}, frac_i[FRAC_W-2:GRD_W]};
            CLS_NORM: begin
                if (ebias > 0) begin
                    res_d   = {sign_i, n_exp, n_man};
                    flags_d = n_flags;
                end else if (ftz_i) begin
                    flags_d.od = 1'b1;
                end else begin
                    res_d   = {sign_i, d_exp, d_man};
                    flags_d = d_flags;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= FLAGS_NONE;
        end else begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    assign result_o = res_q;
    assign nx_o     = flags_q.nx;
    assign of_o     = flags_q.of;
    assign uf_o     = flags_q.uf;
    assign nv_o     = flags_q.nv;
    assign od_o     = flags_q.od;
endmodule

// File: rtl/fpr_round_pack_chk.sv
module fpr_round_pack_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int GRD_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           cls_i,
    input logic [EXP_W+MAN_W:0] result_o,
    input logic                 nx_o,
    input logic                 of_o,
    input logic                 uf_o,
    input logic                 nv_o,
    input logic                 od_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R11: underflow only alongside inexact
    p_uf_needs_nx_r11: assert property (@(posedge clk) disable iff (rst)
        uf_o |-> nx_o);

    // R6: overflow comes with inexact and never with invalid
    p_of_flags_r6: assert property (@(posedge clk) disable iff (rst)
        of_o |-> (nx_o && !nv_o && !uf_o));

    // R7: invalid stands alone and comes with the all-ones magnitude
    p_alt_nv_r7: assert property (@(posedge clk) disable iff (rst)
        nv_o |-> (!nx_o && !of_o && !uf_o && (result_o[EXP_W+MAN_W-1:0] == '1)));

    // R8: a flushed result has zero magnitude and no other flag
    p_ftz_zero_r8: assert property (@(posedge clk) disable iff (rst)
        od_o |-> ((result_o[EXP_W+MAN_W-1:0] == '0) && !nx_o && !uf_o && !of_o));

    // R12: infinity class packs to an infinity with no flags
    p_inf_pack_r12: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cls_i) == 3'd2) |->
            ((result_o[EXP_W+MAN_W-1:MAN_W] == '1) && (result_o[MAN_W-1:0] == '0) &&
             !nx_o && !of_o && !uf_o && !nv_o && !od_o));

    // R12: zero class packs to zero magnitude
    p_zero_pack_r12: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cls_i) == 3'd0) |-> (result_o[EXP_W+MAN_W-1:0] == '0));
endmodule

bind fpr_round_pack fpr_round_pack_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cls_i    (cls_i),
    .result_o (result_o),
    .nx_o     (nx_o),
    .of_o     (of_o),
    .uf_o     (uf_o),
    .nv_o     (nv_o),
    .od_o     (od_o)
);

// File: tb/tb_fpr_round_pack.sv
`timescale 1ns/1ps
module tb_fpr_round_pack;
    localparam int G  = 8;
    localparam int M  = 23;
    localparam int FW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cls = '0;
    logic        sgn = 1'b0;
    logic signed [10:0] ex = '0;
    logic [31:0] fr = '0;
    logic [2:0]  rm = '0;
    logic        ftz = 1'b0, tb = 1'b0, alt = 1'b0;
    logic [31:0] result_o;
    logic        nx_o, of_o, uf_o, nv_o, od_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;
    logic [36:0] exq[$];
    string       tq[$];

    always #5 clk = ~clk;

    fpr_round_pack dut (
        .clk(clk), .rst(rst), .cls_i(cls), .sign_i(sgn), .exp_i(ex), .frac_i(fr),
        .rmode_i(rm), .ftz_i(ftz), .tiny_before_i(tb), .alt_i(alt),
        .result_o(result_o), .nx_o(nx_o), .of_o(of_o), .uf_o(uf_o), .nv_o(nv_o), .od_o(od_o)
    );

    function automatic longint incv(int r, int s, longint f);
        longint half = longint'(1) << (G - 1);
        longint msk  = (longint'(1) << G) - 1;
        case (r)
            0: return ((f & ((longint'(1) << (G + 1)) - 1)) != half) ? half : 0;
            1: return half;
            3: return s ? 0 : msk;
            4: return s ? msk : 0;
            5: return ((f >> G) & 1) ? 0 : msk;
            default: return 0;
        endcase
    endfunction

    // Behavioural model; returns {result, nx, of, uf, nv, od}
    function automatic logic [36:0] model(int c, int s, int eu, longint f,
                                          int r, int z, int t, int a);
        longint mm = (longint'(1) << M) - 1;
        longint man = 0;
        longint f2;
        int e = 0, sh;
        bit nx = 0, of = 0, uf = 0, nv = 0, od = 0, tiny, sat;
        if (c == 2) begin e = 255; man = 0; end
        else if (c == 3 || c == 4) begin e = 255; man = (f >> G) & mm; end
        else if (c == 1) begin
            e = eu + 127;
            if (e > 0) begin
                if ((f & 255) != 0) begin
                    nx = 1;
                    f = f + incv(r, s, f);
                    if ((f >> FW) != 0) begin f = f >> 1; e = e + 1; end
                end
                man = (f >> G) & mm;
                if (a != 0) begin
                    if (e > 255) begin nx = 0; nv = 1; e = 255; man = mm; end
                end else if (e >= 255) begin
                    of = 1; nx = 1;
                    sat = (r == 2 || r == 5 || r > 5 || (r == 3 && s != 0) || (r == 4 && s == 0));
                    if (sat) begin e = 254; man = mm; end
                    else begin e = 255; man = 0; end
                end
            end else if (z != 0) begin
                od = 1; e = 0; man = 0;
            end else begin
                tiny = (t != 0) || (e < 0) || (((f + incv(r, s, f)) >> FW) == 0);
                sh = 1 - e;
                if (sh >= FW) f2 = (f != 0) ? 1 : 0;
                else f2 = (f >> sh) | (((f & ((longint'(1) << sh) - 1)) != 0) ? 1 : 0);
                if ((f2 & 255) != 0) begin
                    nx = 1;
                    f2 = f2 + incv(r, s, f2);
                end
                e = int'((f2 >> (FW - 1)) & 1);
                man = (f2 >> G) & mm;
                uf = tiny && nx;
            end
        end
        return {s[0], e[7:0], man[22:0], nx, of, uf, nv, od};
    endfunction

    task automatic compare_front();
        logic [36:0] want;
        logic [36:0] got;
        string tg;
        if (exq.size() > 0) begin
            want = exq.pop_front();
            tg = tq.pop_front();
            got = {result_o, nx_o, of_o, uf_o, nv_o, od_o};
            nvec++;
            if (got !== want)
                begin nbad++; $display("FAIL %s: got %h expected %h", tg, got, want); end
        end
    endtask

    task automatic vec(int c, int s, int e, longint f, int r, int z, int t, int a, string tag);
        @(negedge clk);
        compare_front();
        cls = 3'(c); sgn = s[0]; ex = 11'(e); fr = f[31:0];
        rm = 3'(r); ftz = z[0]; tb = t[0]; alt = a[0];
        exq.push_back(model(c, s, e, f, r, z, t, a));
        tq.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cls = 3'd2; sgn = 1'b1; fr = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        nvec++;
        if ({result_o, nx_o, of_o, uf_o, nv_o, od_o} !== 37'h0)
            begin nbad++; $display("FAIL R13: got %h expected 0", {result_o, nx_o, of_o, uf_o, nv_o, od_o}); end
        rst = 1'b0;
        cls = 3'd0;

        // R1 nearest-even ties and above-half
        vec(1, 0, 0, 64'h80000080, 0, 0, 0, 0, "R1");
        vec(1, 0, 0, 64'h80000180, 0, 0, 0, 0, "R1");
        vec(1, 1, 3, 64'h80000081, 0, 0, 0, 0, "R1");
        vec(1, 0, 0, 64'h80000000, 6, 0, 0, 0, "R1");
        // R2 ties-away and toward zero
        vec(1, 0, 0, 64'h80000080, 1, 0, 0, 0, "R2");
        vec(1, 1, 0, 64'h800000FF, 2, 0, 0, 0, "R2");
        // R3 directed modes
        vec(1, 0, 0, 64'h80000001, 3, 0, 0, 0, "R3");
        vec(1, 1, 0, 64'h80000001, 3, 0, 0, 0, "R3");
        vec(1, 1, 0, 64'h80000001, 4, 0, 0, 0, "R3");
        vec(1, 0, 0, 64'h80000001, 4, 0, 0, 0, "R3");
        // R4 round to odd
        vec(1, 0, 0, 64'h80000001, 5, 0, 0, 0, "R4");
        vec(1, 0, 0, 64'h80000101, 5, 0, 0, 0, "R4");
        // R5 carry renormalisation
        vec(1, 0, 0, 64'hFFFFFFFF, 0, 0, 0, 0, "R5");
        vec(1, 1, 20, 64'hFFFFFF80, 1, 0, 0, 0, "R5");
        // R6 overflow in every mode and sign
        for (int r = 0; r < 6; r++)
            for (int s = 0; s < 2; s++)
                vec(1, s, 128, 64'h80000000, r, 0, 0, 0, "R6");
        vec(1, 0, 127, 64'hFFFFFFFF, 0, 0, 0, 0, "R6");
        vec(1, 1, 127, 64'hFFFFFFFF, 2, 0, 0, 0, "R6");
        // R7 alternative encoding
        vec(1, 0, 128, 64'h80000000, 0, 0, 0, 1, "R7");
        vec(1, 1, 129, 64'h80000000, 0, 0, 0, 1, "R7");
        vec(1, 0, 128, 64'hFFFFFFFF, 0, 0, 0, 1, "R7");
        // R8 flush
        vec(1, 1, -127, 64'hC0000001, 0, 1, 0, 0, "R8");
        vec(1, 0, -200, 64'h80000000, 3, 1, 1, 0, "R8");
        // R9 tininess edge
        vec(1, 0, -127, 64'hFFFFFFFF, 0, 0, 0, 0, "R9");
        vec(1, 0, -127, 64'hFFFFFFFF, 0, 0, 1, 0, "R9");
        vec(1, 0, -127, 64'hFFFFFF00, 3, 0, 0, 0, "R9");
        vec(1, 1, -128, 64'hFFFFFFFF, 4, 0, 0, 0, "R9");
        // R10 shift, sticky and recomputed increment
        vec(1, 0, -140, 64'hA5A5A5A5, 0, 0, 0, 0, "R10");
        vec(1, 0, -200, 64'h80000000, 3, 0, 0, 0, "R10");
        vec(1, 1, -200, 64'h80000000, 3, 0, 0, 0, "R10");
        vec(1, 0, -133, 64'h80000C00, 5, 0, 0, 0, "R10");
        vec(1, 0, -126, 64'hC0000180, 0, 0, 0, 0, "R10");
        // R11 exact tiny versus inexact tiny
        vec(1, 0, -130, 64'h80000000, 0, 0, 1, 0, "R11");
        vec(1, 0, -130, 64'h80000010, 0, 0, 1, 0, "R11");
        // R12 special classes
        vec(0, 1, 50, 64'hFFFFFFFF, 0, 0, 0, 0, "R12");
        vec(2, 1, 0, 64'h12345678, 3, 0, 0, 0, "R12");
        vec(3, 0, 0, 64'hC0001234, 0, 0, 0, 0, "R12");
        vec(4, 1, 0, 64'h20ABCDEF, 0, 0, 0, 1, "R12");
        vec(6, 0, 10, 64'h80000001, 0, 0, 0, 0, "R12");
        // R13 back-to-back vectors compared on every clock
        vec(1, 0, 1, 64'h80000001, 3, 0, 0, 0, "R13");
        vec(1, 1, 2, 64'h80000001, 4, 0, 0, 0, "R13");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int c, e, r;
            longint f;
            c = ($urandom_range(0, 9) < 8) ? 1 : int'($urandom_range(0, 7));
            e = int'($urandom_range(0, 330)) - 185;
            r = int'($urandom_range(0, 7));
            f = longint'({32'h0, 32'h80000000 | $urandom});
            vec(c, int'($urandom_range(0, 1)), e, f, r,
                ($urandom_range(0, 7) == 0) ? 1 : 0,
                int'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0) ? 1 : 0, "R1");
        end
        @(negedge clk);
        compare_front();
        finish_run();
    end
endmodule